// File: doc/BRIEF.md
# Free-Running Time Base with Compare Interrupt

This block is a memory-mapped system time base. A 56-bit counter advances by one on every clock while the count-enable input is high and wraps to zero past its largest value. A single compare channel holds a 56-bit target. When that channel is armed and the counter has reached or passed the target, a status flag is set. The flag drives an interrupt line unless the line is masked.

Software reaches the block over a plain 32-bit register bus with single-cycle strobes. Each 56-bit quantity is split into a low word and a high word, and the high word holds 24 significant bits. A read returns its data one cycle after the read strobe. Both words come from one counter register that changes in a single step, so a high/low/high read sequence gives a coherent value whenever the two high reads match.

The interrupt is acknowledged by clearing the arm bit in the control register. There is no separate clear operation.

Top module: `sysTimer`

## Requirements
- R1: After reset the counter is zero. While `cntEn` is high it increases by one on every rising clock edge, modulo 2^56.
- R2: While `cntEn` is low the counter holds its value.
- R3: A read at offset 0x8 returns counter bits 31:0. A read at offset 0xC returns counter bits 55:32 in bits 23:0, with bits 31:24 zero. Read data appears on `busRdata` on the cycle after `busRdEn` and reflects the counter value at the edge that captured the strobe.
- R4: Offset 0x10020 holds compare bits 31:0 and offset 0x10024 holds compare bits 55:32 in its bits 23:0. Both offsets can be written and read back. Bits 31:24 of the high word are not stored and read as zero.
- R5: The control register is at offset 0x1002C. Bit 0 arms the compare and bit 1 masks the interrupt. Bit 2 reads back the status flag and ignores writes. All other bits read as zero.
- R6: While armed, the status flag sets at the first edge at which compare ≤ counter. It then stays set, even if the compare value changes, until the arm bit is cleared.
- R7: A write that clears the arm bit clears the status flag at the same edge. The flag never sets while the block is disarmed.
- R8: `irq` is high exactly when the status flag is set and the mask bit is 0.
- R9: Reads of unmapped offsets return zero. Writes to unmapped offsets or to the counter words change nothing.
- R10: Reset leaves compare = 0, control = 0 and `irq` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the counter and the registers |
| rst | input | 1 | Synchronous reset, active high |
| cntEn | input | 1 | Count enable |
| busAddr | input | 17 | Byte offset of the access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busRdata | output | 32 | Read data, valid the cycle after `busRdEn` |
| irq | output | 1 | Compare interrupt, active high |

## Verification
The assertions assume that reset is held from time zero and that every input changes only between clock edges. The status properties skip any cycle that carries a bus write, because such a write can re-arm the block or move the compare value in the same edge. The stimulus therefore issues one strobe at a time and always programs the compare words before it arms the block. Since the counter cannot be preloaded, a wrap-around is never reached in the run, and the modulo behaviour rests on the increment property alone.

// File: rtl/sysTimerPkg.sv
package sysTimerPkg;

  // control register bit positions (software-visible)
  localparam int ARM_BIT  = 0;
  localparam int MASK_BIT = 1;
  localparam int STAT_BIT = 2;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CNT_LO,
    RD_CNT_HI,
    RD_CMP_LO,
    RD_CMP_HI,
    RD_CTRL
  } rdSelE;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic  wrCmpLo;
    logic  wrCmpHi;
    logic  wrCtrl;
    rdSelE rdSel;
  } strobeT;

endpackage

// File: rtl/sysTimerDecode.sv
module sysTimerDecode
  import sysTimerPkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int CNT_LO_OFS = 'h00008,
  parameter int CNT_HI_OFS = 'h0000C,
  parameter int CMP_LO_OFS = 'h10020,
  parameter int CMP_HI_OFS = 'h10024,
  parameter int CTRL_OFS   = 'h1002C
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output strobeT            stb
);

  logic hitCntLo, hitCntHi, hitCmpLo, hitCmpHi, hitCtrl;

  always_comb begin
    hitCntLo = (busAddr == ADDR_W'(CNT_LO_OFS));
    hitCntHi = (busAddr == ADDR_W'(CNT_HI_OFS));
    hitCmpLo = (busAddr == ADDR_W'(CMP_LO_OFS));
    hitCmpHi = (busAddr == ADDR_W'(CMP_HI_OFS));
    hitCtrl  = (busAddr == ADDR_W'(CTRL_OFS));
  end

  always_comb begin
    // counter words are read-only: no write strobe exists for them
    stb.wrCmpLo = busWrEn && hitCmpLo;
    stb.wrCmpHi = busWrEn && hitCmpHi;
    stb.wrCtrl  = busWrEn && hitCtrl;
    stb.rdSel   = RD_NONE;
    if (busRdEn) begin
      if (hitCntLo)      stb.rdSel = RD_CNT_LO;
      else if (hitCntHi) stb.rdSel = RD_CNT_HI;
      else if (hitCmpLo) stb.rdSel = RD_CMP_LO;
      else if (hitCmpHi) stb.rdSel = RD_CMP_HI;
      else if (hitCtrl)  stb.rdSel = RD_CTRL;
    end
  end

endmodule

// File: rtl/sysTimerCounter.sv
module sysTimerCounter #(
  parameter int CNT_W = 56
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cntEn,
  output logic [CNT_W-1:0] cntVal
);

  // single register: both halves change in the same edge
  always_ff @(posedge clk) begin
    if (rst)        cntVal <= '0;
    else if (cntEn) cntVal <= cntVal + CNT_W'(1);
  end

endmodule

// File: rtl/sysTimerCore.sv
module sysTimerCore
  import sysTimerPkg::*;
#(
  parameter int CNT_W  = 56,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeT            stb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [CNT_W-1:0]  cntVal,
  output logic [DATA_W-1:0] busRdata,
  output logic [CNT_W-1:0]  cmpVal,
  output logic              armVal,
  output logic              maskVal,
  output logic              statusVal
);

  localparam int HI_W  = CNT_W - DATA_W;
  localparam int PAD_W = DATA_W - HI_W;

  logic armNext, maskNext, reached;
  logic [DATA_W-1:0] rdMux, ctrlWord;

  always_comb begin
    armNext  = stb.wrCtrl ? busWdata[ARM_BIT]  : armVal;
    maskNext = stb.wrCtrl ? busWdata[MASK_BIT] : maskVal;
    reached  = (cmpVal <= cntVal);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmpVal    <= '0;
      armVal    <= 1'b0;
      maskVal   <= 1'b0;
      statusVal <= 1'b0;
    end else begin
      if (stb.wrCmpLo) cmpVal[DATA_W-1:0]     <= busWdata;
      if (stb.wrCmpHi) cmpVal[CNT_W-1:DATA_W] <= busWdata[HI_W-1:0];
      armVal    <= armNext;
      maskVal   <= maskNext;
      // sticky while armed, cleared in the edge that disarms
      statusVal <= armNext && (statusVal || reached);
    end
  end

  always_comb begin
    ctrlWord           = '0;
    ctrlWord[ARM_BIT]  = armVal;
    ctrlWord[MASK_BIT] = maskVal;
    ctrlWord[STAT_BIT] = statusVal;
    unique case (stb.rdSel)
      RD_CNT_LO: rdMux = cntVal[DATA_W-1:0];
      RD_CNT_HI: rdMux = {{PAD_W{1'b0}}, cntVal[CNT_W-1:DATA_W]};
      RD_CMP_LO: rdMux = cmpVal[DATA_W-1:0];
      RD_CMP_HI: rdMux = {{PAD_W{1'b0}}, cmpVal[CNT_W-1:DATA_W]};
      RD_CTRL:   rdMux = ctrlWord;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) busRdata <= '0;
    else     busRdata <= rdMux;
  end

endmodule

// File: rtl/sysTimer.sv
module sysTimer
  import sysTimerPkg::*;
#(
  parameter int CNT_W  = 56,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cntEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);

  strobeT           stb;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] cmpVal;
  logic             armVal, maskVal, statusVal;

  sysTimerDecode #(.ADDR_W(ADDR_W)) uDecode (
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn), .stb(stb)
  );

  sysTimerCounter #(.CNT_W(CNT_W)) uCounter (
    .clk(clk), .rst(rst), .cntEn(cntEn), .cntVal(cntVal)
  );

  sysTimerCore #(.CNT_W(CNT_W), .DATA_W(DATA_W)) uCore (
    .clk(clk), .rst(rst), .stb(stb), .busWdata(busWdata), .cntVal(cntVal),
    .busRdata(busRdata), .cmpVal(cmpVal), .armVal(armVal),
    .maskVal(maskVal), .statusVal(statusVal)
  );

  assign irq = statusVal && !maskVal;

endmodule

// File: rtl/sysTimerChk.sv
module sysTimerChk #(
  parameter int CNT_W = 56
) (
  input logic             clk,
  input logic             rst,
  input logic             cntEn,
  input logic             busWrEn,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic             arm,
  input logic             mask,
  input logic             status
);

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    cntEn |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cntEn |=> $stable(cnt));

  // R6
  status_set_chk: assert property (@(posedge clk) disable iff (rst)
    (arm && (cmp <= cnt) && !busWrEn) |=> status);

  // R6
  status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (status && !busWrEn) |=> status);

  // R7
  disarm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !arm |-> !status);

  // R8
  mask_block_chk: assert property (@(posedge clk) disable iff (rst)
    mask |-> !irq);

  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!irq && !arm && !mask && cmp == '0 && cnt == '0));

endmodule

bind sysTimer sysTimerChk #(.CNT_W(CNT_W)) chk (
  .clk(clk), .rst(rst), .cntEn(cntEn), .busWrEn(busWrEn), .irq(irq),
  .cnt(cntVal), .cmp(cmpVal), .arm(armVal), .mask(maskVal), .status(statusVal)
);

// File: tb/tb_sysTimer.sv
`timescale 1ns/1ps
module tb_sysTimer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cntEn = 1'b0;
  logic [16:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdata;
  logic        irq;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  logic [55:0] modelCnt = '0;
  logic        rdIssued = 1'b0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  sysTimer dut (
    .clk(clk), .rst(rst), .cntEn(cntEn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWdata(busWdata), .busRdEn(busRdEn),
    .busRdata(busRdata), .irq(irq)
  );

  // reference counter built from R1/R2
  always @(posedge clk) begin
    if (rst)        modelCnt <= '0;
    else if (cntEn) modelCnt <= modelCnt + 56'd1;
    rdIssued <= busRdEn;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per completed read
  always @(negedge clk) begin
    if (rdIssued) begin
      if (expQ.size() == 0) check("scoreboard-empty", 32'd1, 32'd0);
      else check(tagQ.pop_front(), busRdata, expQ.pop_front());
    end
  end

  task automatic busWrite(logic [16:0] a, logic [31:0] d);
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [16:0] a, logic [31:0] exp, string tag);
    busAddr = a; busRdEn = 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic readCntLo(string tag);
    busRead(17'h00008, modelCnt[31:0], tag);
  endtask

  task automatic readCntHi(string tag);
    busRead(17'h0000C, {8'h00, modelCnt[55:32]}, tag);
  endtask

  task automatic finish();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nErr++; nChecks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    logic [55:0] target;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 irq after reset", {31'd0, irq}, 32'd0);
    check("R10 rdata after reset", busRdata, 32'd0);
    busRead(17'h1002C, 32'd0, "R10 ctrl reset");
    busRead(17'h10020, 32'd0, "R10 cmp lo reset");
    busRead(17'h10024, 32'd0, "R10 cmp hi reset");
    readCntLo("R1 counter zero after reset");

    // R1 counting, R3 hi-lo-hi
    cntEn = 1'b1;
    repeat (7) @(negedge clk);
    readCntLo("R1 counter lo");
    readCntHi("R3 hi first");
    readCntLo("R3 lo middle");
    readCntHi("R3 hi second");

    // R2 hold
    cntEn = 1'b0;
    repeat (5) @(negedge clk);
    readCntLo("R2 held lo");
    repeat (5) @(negedge clk);
    readCntLo("R2 still held lo");
    cntEn = 1'b1;

    // R4 compare readback, upper bits dropped
    busWrite(17'h10024, 32'hFFFF_FFFF);
    busRead(17'h10024, 32'h00FF_FFFF, "R4 cmp hi 24 bits");
    busWrite(17'h10020, 32'hA5A5_0F0F);
    busRead(17'h10020, 32'hA5A5_0F0F, "R4 cmp lo");

    // R9 ignored writes and unmapped reads
    busWrite(17'h00008, 32'h0);
    busWrite(17'h0000C, 32'hFF);
    readCntLo("R9 counter lo unchanged");
    readCntHi("R9 counter hi unchanged");
    busWrite(17'h10028, 32'hFFFF_FFFF);
    busRead(17'h10028, 32'd0, "R9 unmapped read");
    busRead(17'h00004, 32'd0, "R9 unmapped read low");
    busRead(17'h1002C, 32'd0, "R9 ctrl untouched");
    busRead(17'h10020, 32'hA5A5_0F0F, "R9 cmp untouched");

    // R5 status bit not writable
    busWrite(17'h1002C, 32'h4);
    busRead(17'h1002C, 32'd0, "R5 status bit write ignored");
    check("R5 irq stays low", {31'd0, irq}, 32'd0);

    // R6 hit timing
    target = modelCnt + 56'd30;
    busWrite(17'h10020, target[31:0]);
    busWrite(17'h10024, {8'h00, target[55:32]});
    busWrite(17'h1002C, 32'h1);
    while (modelCnt != target) @(negedge clk);
    check("R6 no irq before compare reached", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R6 irq once compare <= counter", {31'd0, irq}, 32'd1);
    busRead(17'h1002C, 32'h5, "R5 ctrl shows status");

    // R6 sticky when compare moves away
    busWrite(17'h10024, 32'h00FF_FFFF);
    repeat (3) @(negedge clk);
    check("R6 status sticky", {31'd0, irq}, 32'd1);

    // R8 mask
    busWrite(17'h1002C, 32'h3);
    check("R8 masked irq low", {31'd0, irq}, 32'd0);
    busRead(17'h1002C, 32'h7, "R8 status kept under mask");
    busWrite(17'h1002C, 32'h1);
    check("R8 unmasked irq high", {31'd0, irq}, 32'd1);

    // R7 disarm clears
    busWrite(17'h1002C, 32'h4);
    check("R7 irq cleared on disarm", {31'd0, irq}, 32'd0);
    busRead(17'h1002C, 32'd0, "R7 status cleared");

    // R7 never sets while disarmed, even with compare far behind
    busWrite(17'h10024, 32'd0);
    busWrite(17'h10020, 32'd0);
    repeat (5) @(negedge clk);
    check("R7 no irq while disarmed", {31'd0, irq}, 32'd0);

    // R6 arming with compare already passed hits at the arming edge
    busWrite(17'h1002C, 32'h1);
    check("R6 immediate hit", {31'd0, irq}, 32'd1);

    // R6 far compare never hits
    busWrite(17'h1002C, 32'h0);
    busWrite(17'h10024, 32'h00FF_FFFF);
    busWrite(17'h1002C, 32'h1);
    repeat (10) @(negedge clk);
    check("R6 far compare no irq", {31'd0, irq}, 32'd0);

    finish();
  end

endmodule